// File: doc/BRIEF.md
# Dual-Lane Depth Span Tester

This block handles the depth side of a scan-line polygon renderer for one horizontal span. Depths are 16 bits and two of them share each 32-bit memory word. The even pixel sits in bits 15:0 and the odd pixel in bits 31:16. The block sweeps the span twice, handling one word per clock. The first sweep only reads. It compares the stored pair against two interpolated depths and records, for each pixel, whether the new depth is closer. The second sweep only writes. It stores the new depth into the lanes that passed and masks the others with per-lane byte-pair enables. Because the depth test and the depth update are separate sweeps, a pixel never needs a read-modify-write.

Each lane has its own 24-bit interpolant in 16.8 fixed point with its own step. The integer part, bits 23:8, is the depth that is compared and written. Both sweeps restart from the same initial values. The per-pixel results stay in a 64-by-2 flag store. A later colour pass reads that store one pixel at a time through a dedicated read port. This limits a span to 128 pixels, and a wider span is split by the caller.

Top module: `zspan_tester`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `mem_we` and `mem_be` are all low.
- R2: The read sweep issues one read per clock. The address starts at `row_base + x_start/2` and rises by one per clock, giving N reads for N = (x_end+1)/2 - x_start/2 word pairs.
- R3: For pair i, lane L's depth is bits 23:8 of (init_L + i*delta_L) mod 2^24. A lane is closer only when this depth is strictly less than the stored value, so an equal depth is not closer.
- R4: The write sweep restarts from the initial values, so the depth written for pair i equals the depth tested for pair i.
- R5: A lane whose pixel lies outside [x_start, x_end) has its flag forced to 0 and is never written, even when its depth would pass.
- R6: The write sweep issues N writes, one per clock, over the same addresses as the reads. `mem_be[0]` enables bits 15:0 and `mem_be[1]` enables bits 31:16, and an enable is set only for a closer lane. Reads carry no enables.
- R7: No read is issued after the first write of a run. There is one clock with no request between the two sweeps.
- R8: `done` is high for exactly one clock. It rises on the (2N+1)-th rising edge after the edge that accepts `start`, which is the edge after the last write, and `busy` falls at that same edge.
- R9: `start` is ignored while `busy` is high. A second start during a run changes neither the run's results nor its timing.
- R10: `flag_out` returns the flag of pixel `flag_idx`. The index is counted from the even pixel at or below `x_start`. Entry `flag_idx/2` supplies the flag, and bit 0 of the index picks the lane.
- R11: A span of the full 128 pixels (64 pairs) is processed completely, including with negative steps.
- R12: Memory read data is taken one clock after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a span; ignored while busy |
| x_start | input | XW | First pixel of the span |
| x_end | input | XW | One past the last pixel of the span |
| row_base | input | MAW | Word address of pixel pair 0 on this line |
| z0_init | input | ZW+FW | Even-lane initial depth, 16.8 |
| z1_init | input | ZW+FW | Odd-lane initial depth, 16.8 |
| dz0 | input | ZW+FW | Even-lane step per pair |
| dz1 | input | ZW+FW | Odd-lane step per pair |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-clock end-of-run pulse |
| mem_req | output | 1 | Memory access this clock |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MAW | Word address |
| mem_be | output | 2 | Per-lane write enables |
| mem_wdata | output | 2*ZW | Write data, odd lane high |
| mem_rdata | input | 2*ZW | Read data, valid one clock after the request |
| flag_idx | input | IW+1 | Pixel index for the flag read port |
| flag_out | output | 1 | Closer flag of that pixel |

## Verification
The properties assume that the caller presents a non-empty span of at most 64 word pairs and that memory answers a read on the following clock. They also assume the line's addresses do not wrap the address space, because the address-step property treats consecutive requests as adjacent words. The stimulus only uses spans with x_end above x_start and word counts from 1 to 64, with row bases chosen so that every access stays inside a 256-word array. The bench memory model returns read data one clock after each read request.

// File: rtl/zspan_tester.sv
module zspan_tester #(
  parameter int XW    = 11,
  parameter int MAW   = 16,
  parameter int ZW    = 16,
  parameter int FW    = 8,
  parameter int PAIRS = 64,
  localparam int ACW  = ZW + FW,
  localparam int IW   = $clog2(PAIRS),
  localparam int DW   = 2 * ZW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [XW-1:0]  x_start,
  input  logic [XW-1:0]  x_end,
  input  logic [MAW-1:0] row_base,
  input  logic [ACW-1:0] z0_init,
  input  logic [ACW-1:0] z1_init,
  input  logic [ACW-1:0] dz0,
  input  logic [ACW-1:0] dz1,
  output logic           busy,
  output logic           done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [1:0]     mem_be,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [IW:0]    flag_idx,
  output logic           flag_out
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_GAP, S_WR} st_t;

  st_t            st;
  logic [XW-1:0]  xs_q, xe_q;
  logic [MAW-1:0] rb_q;
  logic [ACW-1:0] z0i, z1i, d0q, d1q, acc0, acc1;
  logic [IW-1:0]  idx, last_q, ri;
  logic           rv;
  logic [ZW-1:0]  rz0, rz1;
  logic [1:0]     rm;
  logic [1:0]     flags [PAIRS];

  wire [XW-1:0] span_pairs = ((x_end + XW'(1)) >> 1) - (x_start >> 1);
  wire [XW-1:0] pair_x     = (xs_q >> 1) + XW'(idx);
  wire [XW-1:0] px_ev      = pair_x << 1;
  wire          lane0_in   = px_ev >= xs_q;
  wire          lane1_in   = (px_ev | XW'(1)) < xe_q;
  wire          at_last    = idx == last_q;

  assign busy      = st != S_IDLE;
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = st == S_WR;
  assign mem_addr  = rb_q + MAW'(pair_x);
  assign mem_be    = mem_we ? flags[idx] : 2'b00;
  assign mem_wdata = {acc1[ACW-1:FW], acc0[ACW-1:FW]};
  assign flag_out  = flags[flag_idx[IW:1]][flag_idx[0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; idx <= '0; last_q <= '0;
      xs_q <= '0; xe_q <= '0; rb_q <= '0;
      z0i <= '0; z1i <= '0; d0q <= '0; d1q <= '0; acc0 <= '0; acc1 <= '0;
      rv <= 1'b0; ri <= '0; rz0 <= '0; rz1 <= '0; rm <= '0;
    end else begin
      done <= 1'b0;
      rv   <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          xs_q <= x_start; xe_q <= x_end; rb_q <= row_base;
          z0i <= z0_init; z1i <= z1_init; d0q <= dz0; d1q <= dz1;
          acc0 <= z0_init; acc1 <= z1_init;
          last_q <= IW'(span_pairs - XW'(1));
          idx <= '0;
          st <= S_RD;
        end
        S_RD: begin
          rv <= 1'b1; ri <= idx;
          rz0 <= acc0[ACW-1:FW]; rz1 <= acc1[ACW-1:FW];
          rm <= {lane1_in, lane0_in};
          acc0 <= acc0 + d0q; acc1 <= acc1 + d1q;
          if (at_last) begin idx <= '0; st <= S_GAP; end
          else idx <= idx + IW'(1);
        end
        S_GAP: begin
          acc0 <= z0i; acc1 <= z1i;
          st <= S_WR;
        end
        S_WR: begin
          acc0 <= acc0 + d0q; acc1 <= acc1 + d1q;
          if (at_last) begin st <= S_IDLE; done <= 1'b1; end
          else idx <= idx + IW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < PAIRS; k++) flags[k] <= 2'b00;
    end else if (rv) begin
      flags[ri] <= {rm[1] & (rz1 < mem_rdata[DW-1:ZW]),
                    rm[0] & (rz0 < mem_rdata[ZW-1:0])};
    end
  end
endmodule

// File: rtl/zspan_tester_chk.sv
module zspan_tester_chk #(
  parameter int MAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           mem_req,
  input logic           mem_we,
  input logic [MAW-1:0] mem_addr,
  input logic [1:0]     mem_be
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !(mem_req && !mem_we)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + MAW'(1))); // R2
  AST_READ_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_be == 2'b00)); // R6
endmodule

bind zspan_tester zspan_tester_chk #(.MAW(MAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/zspan_tester_test.sv
module zspan_tester_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] x_start = '0, x_end = '0;
  logic [15:0] row_base = '0;
  logic [23:0] z0_init = '0, z1_init = '0, dz0 = '0, dz1 = '0;
  logic        busy, done, mem_req, mem_we, flag_out;
  logic [15:0] mem_addr;
  logic [1:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [6:0]  flag_idx = '0;

  logic [31:0] mem     [256];
  logic [31:0] exp_mem [256];
  logic [127:0] exp_flag;
  int n_chk = 0, n_fail = 0;
  int n_rd, n_wr, raw_err;
  bit wr_seen;

  always #(CLK_P/2) clk = ~clk;

  zspan_tester uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_start(x_start), .x_end(x_end),
    .row_base(row_base), .z0_init(z0_init), .z1_init(z1_init), .dz0(dz0), .dz1(dz1),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .flag_idx(flag_idx), .flag_out(flag_out)
  );

  // memory model, read latency one clock (R12)
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        wr_seen <= 1'b1;
        n_wr <= n_wr + 1;
        if (mem_be[0]) mem[mem_addr[7:0]][15:0]  <= mem_wdata[15:0];
        if (mem_be[1]) mem[mem_addr[7:0]][31:16] <= mem_wdata[31:16];
      end else begin
        n_rd <= n_rd + 1;
        if (wr_seen) raw_err <= raw_err + 1;
        mem_rdata <= mem[mem_addr[7:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic fill(input logic [31:0] seed);
    for (int k = 0; k < 256; k++) mem[k] = (32'(k) * 32'h9E3779B1) ^ seed;
  endtask

  task automatic run_span(input int xs, input int xe, input int rb,
                          input logic [23:0] z0, input logic [23:0] z1,
                          input logic [23:0] d0, input logic [23:0] d1,
                          input int poke, input string tag);
    int pb, np, a, cyc;
    logic [23:0] t0, t1;
    logic [15:0] e0, e1;
    bit v0, v1, c0, c1;
    pb = xs / 2;
    np = (xe + 1) / 2 - pb;
    for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
    exp_flag = '0;
    for (int i = 0; i < np; i++) begin
      t0 = z0 + 24'(i) * d0;  t1 = z1 + 24'(i) * d1;
      e0 = t0[23:8];          e1 = t1[23:8];
      a  = rb + pb + i;
      v0 = (2 * (pb + i)) >= xs;
      v1 = (2 * (pb + i) + 1) < xe;
      c0 = v0 && (e0 < mem[a][15:0]);
      c1 = v1 && (e1 < mem[a][31:16]);
      if (c0) exp_mem[a][15:0]  = e0;
      if (c1) exp_mem[a][31:16] = e1;
      exp_flag[2*i]   = c0;
      exp_flag[2*i+1] = c1;
    end
    @(negedge clk);
    x_start = 11'(xs); x_end = 11'(xe); row_base = 16'(rb);
    z0_init = z0; z1_init = z1; dz0 = d0; dz1 = d1;
    wr_seen = 1'b0; raw_err = 0; n_rd = 0; n_wr = 0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (cyc < 1000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == poke) begin
        start = 1'b1; x_start = 11'd0; x_end = 11'd2; row_base = 16'd200;
        z0_init = 24'h0; z1_init = 24'h0;
      end
      if (cyc == poke + 1) start = 1'b0;
      if (done) break;
    end
    chk(cyc == 2*np + 1, {tag, " R8 latency"}, cyc, 2*np + 1);
    @(negedge clk);
    chk(!done, {tag, " R8 done width"}, done, 0);
    chk(!busy, {tag, " R8 busy after done"}, busy, 0);
    repeat (2) @(negedge clk);
    chk(!busy, {tag, " R9 no second run"}, busy, 0);
    chk(n_rd == np, {tag, " R2 read count"}, n_rd, np);
    chk(n_wr == np, {tag, " R6 write count"}, n_wr, np);
    chk(raw_err == 0, {tag, " R7 read after write"}, raw_err, 0);
    for (int k = 0; k < 256; k++)
      chk(mem[k] === exp_mem[k], {tag, " R3 R4 R5 R6 word"}, mem[k], exp_mem[k]);
    for (int p = 0; p < 2*np; p++) begin
      flag_idx = 7'(p);
      #1;
      chk(flag_out === exp_flag[p], {tag, " R10 flag"}, flag_out, exp_flag[p]);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(!busy && !done, "R1 busy/done at reset", {busy, done}, 0);
    chk(!mem_req && !mem_we && mem_be == 2'b00, "R1 memory idle at reset",
        {mem_req, mem_we, mem_be}, 0);
  endtask

  task automatic t_aligned;
    fill(32'h5A5AC3C3);
    run_span(0, 16, 8, 24'h700080, 24'h710000, 24'h020040, 24'h020010, -10, "aligned");
  endtask

  task automatic t_ties;
    fill(32'h13572468);
    mem[22] = {16'h3101, 16'h3000};
    mem[23] = {16'h3200, 16'h30FF};
    run_span(4, 8, 20, 24'h300000, 24'h310000, 24'h010000, 24'h010000, -10, "ties");
    chk(mem[22] === {16'h3100, 16'h3000}, "R3 tie kept, closer written", mem[22],
        {16'h3100, 16'h3000});
    chk(mem[23] === {16'h3200, 16'h30FF}, "R3 tie and farther kept", mem[23],
        {16'h3200, 16'h30FF});
  endtask

  task automatic t_odd_edges;
    for (int k = 0; k < 256; k++) mem[k] = 32'hFFFF_FFFF;
    run_span(7, 25, 50, 24'h100000, 24'h100800, 24'h001000, 24'h001000, -10, "odd");
    chk(mem[53][15:0] === 16'hFFFF, "R5 leading lane untouched", mem[53][15:0], 16'hFFFF);
    chk(mem[62][31:16] === 16'hFFFF, "R5 trailing lane untouched", mem[62][31:16], 16'hFFFF);
    flag_idx = 7'd0; #1;
    chk(flag_out === 1'b0, "R5 leading flag", flag_out, 0);
    flag_idx = 7'd19; #1;
    chk(flag_out === 1'b0, "R5 trailing flag", flag_out, 0);
  endtask

  task automatic t_single;
    for (int k = 0; k < 256; k++) mem[k] = 32'hFFFF_FFFF;
    run_span(9, 10, 30, 24'h010000, 24'h020000, 24'h0, 24'h0, -10, "single");
    chk(mem[34] === {16'h0200, 16'hFFFF}, "R5 single odd pixel", mem[34],
        {16'h0200, 16'hFFFF});
  endtask

  task automatic t_full;
    fill(32'hC0FFEE11);
    run_span(0, 128, 40, 24'hC00000, 24'hBFFF80, 24'hFFFD00, 24'hFFFD00, -10, "R11 full");
  endtask

  task automatic t_busy_start;
    fill(32'h0BADF00D);
    run_span(2, 30, 120, 24'h800000, 24'h7FF000, 24'hFFE000, 24'h002000, 5, "R9 poke");
    chk(mem[200] === exp_mem[200], "R9 poked row untouched", mem[200], exp_mem[200]);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_aligned;
    t_ties;
    t_odd_edges;
    t_single;
    t_full;
    t_busy_start;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule